// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block keeps the boundary and trip-count state for a small set of nested hardware loops in an in-order core. A setup operation in decode loads a loop's first address, last address or trip count. The addresses come either from a PC-relative immediate, which is scaled to whole words, or from a general-purpose register value. The loop boundaries can be changed only by these setup operations. A generic CSR write aimed at them is refused.

On the decode side, the block raises a combinational illegal-instruction flag in three cases: a CSR write aimed at the loop state, a register-sourced address that is not word-aligned, and a control-transfer or system instruction whose PC lies inside an active loop body. On the fetch side, it watches the fetch PC. When the fetch PC reaches the last address of a live loop, the block requests a jump back to that loop's first address and counts one trip down. The innermost loop, which is index 0, wins when two loops end on the same address.

Both interfaces are plain qualified pulses (`dec_valid`, `fetch_valid`). The block accepts every qualified cycle and never applies back-pressure, so there is no ready signal. Outputs are valid in the same cycle as the inputs they depend on.

Top module: `hwloop_ctrl`

## Requirements
- R1: A decode operation of kind CSR_WR (op_kind=6) raises `illegal` and leaves every loop start and end register unchanged.
- R2: START_REG (op_kind=3) and END_REG (op_kind=4) with a word-aligned `op_rdata` load that value into the start or end register of loop `op_loop` on the next clock edge.
- R3: START_IMM (op_kind=1) and END_IMM (op_kind=2) load `dec_pc + sign_extend(op_imm)*4` into the selected register, so the loaded address is always word-aligned.
- R4: START_REG or END_REG whose `op_rdata[1:0]` is nonzero raises `illegal`, and the target register keeps its value.
- R5: While `dec_pc` lies in an active loop body, the instruction classes jump(1), branch(2), machine return(3), debug return(4), wait-for-interrupt(5), environment call(6) and fence(7) raise `illegal`. Class other(0) never does, and no class does when `dec_pc` is outside every active body.
- R6: A loop is active when its count is nonzero and start <= PC <= end, with both bounds inclusive.
- R7: When `fetch_valid` is high, `fetch_pc` equals the end of a loop and that loop's count is above 1, `branch_back` is high with `branch_target` equal to that loop's start in the same cycle. The count drops by one at the next edge.
- R8: In the same fetch situation with a count of exactly 1, `branch_back` stays low and the count drops to 0.
- R9: When several loops end on the same fetched address, the lowest loop index alone supplies the target and is decremented. The other loops keep their counts.
- R10: COUNT (op_kind=5) loads `op_rdata[CW-1:0]` into the selected count. A count of zero makes the loop inactive, and it never produces `branch_back`.
- R11: `illegal` depends combinationally on the decode inputs. A synchronous active-low reset clears every count, start and end to zero.
- R12: A setup write beats a same-cycle decrement of the same loop, and a decode operation flagged `illegal` writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decode slot holds a valid instruction |
| op_kind | input | 3 | Setup operation kind (0 none, 1..6 as in R1 to R10) |
| op_loop | input | LIDX_W | Loop index addressed by the setup operation |
| op_imm | input | IMM_W | Signed word offset for the immediate forms |
| op_rdata | input | AW | Register operand (address or count) |
| dec_pc | input | AW | PC of the instruction in decode |
| dec_class | input | 3 | Instruction class of the decode instruction |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | AW | Current fetch address |
| lp_start | output | N_LOOPS*AW | Start addresses, loop i at bits [i*AW +: AW] |
| lp_end | output | N_LOOPS*AW | End addresses, same packing |
| lp_count | output | N_LOOPS*CW | Remaining trip counts, loop i at [i*CW +: CW] |
| illegal | output | 1 | Decode instruction is illegal |
| branch_back | output | 1 | Redirect fetch to `branch_target` |
| branch_target | output | AW | Start address of the looping level |

## Verification
The bench builds the block with two loop levels, 32-bit addresses, 16-bit counts and a 12-bit immediate. Two levels are enough to nest loop 0 inside loop 1, to make both end on one address for the priority case, and to see that an address inside only the outer loop is still guarded. A negative immediate exercises the sign extension and the scale by four. The inclusive-bound cases sit exactly on the outer loop's first and last addresses and one word beyond each.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  typedef enum logic [2:0] {
    OPK_NONE      = 3'd0,
    OPK_START_IMM = 3'd1,
    OPK_END_IMM   = 3'd2,
    OPK_START_REG = 3'd3,
    OPK_END_REG   = 3'd4,
    OPK_COUNT     = 3'd5,
    OPK_CSR_WR    = 3'd6
  } op_kind_e;

  typedef enum logic [2:0] {
    CLS_OTHER  = 3'd0,
    CLS_JUMP   = 3'd1,
    CLS_BRANCH = 3'd2,
    CLS_MRET   = 3'd3,
    CLS_DRET   = 3'd4,
    CLS_WFI    = 3'd5,
    CLS_ECALL  = 3'd6,
    CLS_FENCE  = 3'd7
  } insn_class_e;

  // Every class apart from "other" is a control transfer or system op.
  function automatic logic class_banned(input logic [2:0] cls);
    return cls != CLS_OTHER;
  endfunction

endpackage

// File: rtl/hwloop_setup_dec.sv
module hwloop_setup_dec
  import hwloop_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IMM_W = 12
) (
  input  logic [2:0]       op_kind,
  input  logic [IMM_W-1:0] op_imm,
  input  logic [AW-1:0]    op_rdata,
  input  logic [AW-1:0]    dec_pc,
  output logic             is_start,
  output logic             is_end,
  output logic             is_count,
  output logic             bad,
  output logic [AW-1:0]    addr
);
  localparam int EXT_W = AW - IMM_W - 2;

  logic [AW-1:0] imm_off;
  logic          reg_form;

  assign imm_off  = {{EXT_W{op_imm[IMM_W-1]}}, op_imm, 2'b00};
  assign reg_form = (op_kind == OPK_START_REG) || (op_kind == OPK_END_REG);

  always_comb begin
    is_start = (op_kind == OPK_START_IMM) || (op_kind == OPK_START_REG);
    is_end   = (op_kind == OPK_END_IMM)   || (op_kind == OPK_END_REG);
    is_count = (op_kind == OPK_COUNT);
    addr     = reg_form ? op_rdata : dec_pc + imm_off;
    bad      = (op_kind == OPK_CSR_WR) || (reg_form && (op_rdata[1:0] != 2'b00));
  end

endmodule

// File: rtl/hwloop_level.sv
module hwloop_level #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          wr_end,
  input  logic          wr_count,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_cnt,
  input  logic          dec_en,
  input  logic [AW-1:0] dec_pc,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] end_q,
  output logic [CW-1:0] count_q,
  output logic          in_body,
  output logic          at_end
);
  logic live;

  assign live    = count_q != '0;
  assign in_body = live && (dec_pc >= start_q) && (dec_pc <= end_q);
  assign at_end  = live && fetch_valid && (fetch_pc == end_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      count_q <= '0;
    end else begin
      if (wr_start) start_q <= wr_addr;
      if (wr_end)   end_q   <= wr_addr;
      if (wr_count)    count_q <= wr_cnt;
      else if (dec_en) count_q <= count_q - CW'(1);
    end
  end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int N_LOOPS = 2,
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int IMM_W   = 12,
  parameter int LIDX_W  = (N_LOOPS > 1) ? $clog2(N_LOOPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dec_valid,
  input  logic [2:0]            op_kind,
  input  logic [LIDX_W-1:0]     op_loop,
  input  logic [IMM_W-1:0]      op_imm,
  input  logic [AW-1:0]         op_rdata,
  input  logic [AW-1:0]         dec_pc,
  input  logic [2:0]            dec_class,
  input  logic                  fetch_valid,
  input  logic [AW-1:0]         fetch_pc,
  output logic [N_LOOPS*AW-1:0] lp_start,
  output logic [N_LOOPS*AW-1:0] lp_end,
  output logic [N_LOOPS*CW-1:0] lp_count,
  output logic                  illegal,
  output logic                  branch_back,
  output logic [AW-1:0]         branch_target
);
  logic               is_start, is_end, is_count, setup_bad, wr_ok;
  logic [AW-1:0]      wr_addr;
  logic [N_LOOPS-1:0] in_body, at_end, dec_en;
  logic [LIDX_W-1:0]  sel;
  logic               hit_any;
  logic [CW-1:0]      sel_count;

  hwloop_setup_dec #(.AW(AW), .IMM_W(IMM_W)) u_dec (
    .op_kind  (op_kind),
    .op_imm   (op_imm),
    .op_rdata (op_rdata),
    .dec_pc   (dec_pc),
    .is_start (is_start),
    .is_end   (is_end),
    .is_count (is_count),
    .bad      (setup_bad),
    .addr     (wr_addr)
  );

  assign illegal = dec_valid && (setup_bad || (class_banned(dec_class) && (|in_body)));
  assign wr_ok   = dec_valid && !illegal;

  for (genvar g = 0; g < N_LOOPS; g++) begin : g_lvl
    logic sel_me;
    assign sel_me = wr_ok && (op_loop == LIDX_W'(g));
    hwloop_level #(.AW(AW), .CW(CW)) u_lvl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_start    (sel_me && is_start),
      .wr_end      (sel_me && is_end),
      .wr_count    (sel_me && is_count),
      .wr_addr     (wr_addr),
      .wr_cnt      (op_rdata[CW-1:0]),
      .dec_en      (dec_en[g]),
      .dec_pc      (dec_pc),
      .fetch_valid (fetch_valid),
      .fetch_pc    (fetch_pc),
      .start_q     (lp_start[g*AW +: AW]),
      .end_q       (lp_end[g*AW +: AW]),
      .count_q     (lp_count[g*CW +: CW]),
      .in_body     (in_body[g]),
      .at_end      (at_end[g])
    );
  end

  // Lowest index (innermost loop) wins when several end together.
  always_comb begin
    hit_any = 1'b0;
    sel     = '0;
    for (int i = N_LOOPS - 1; i >= 0; i--) begin
      if (at_end[i]) begin
        hit_any = 1'b1;
        sel     = LIDX_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_LOOPS; i++) dec_en[i] = hit_any && (sel == LIDX_W'(i));
  end

  assign sel_count     = lp_count[sel*CW +: CW];
  assign branch_back   = hit_any && (sel_count > CW'(1));
  assign branch_target = lp_start[sel*AW +: AW];

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int N_LOOPS = 2,
  parameter int AW      = 32,
  parameter int CW      = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dec_valid,
  input logic [2:0]            op_kind,
  input logic [AW-1:0]         op_rdata,
  input logic                  fetch_valid,
  input logic [AW-1:0]         fetch_pc,
  input logic [N_LOOPS*AW-1:0] lp_start,
  input logic [N_LOOPS*AW-1:0] lp_end,
  input logic [N_LOOPS*CW-1:0] lp_count,
  input logic                  illegal,
  input logic                  branch_back,
  input logic [AW-1:0]         branch_target
);
  logic reg_form;
  assign reg_form = (op_kind == 3'd3) || (op_kind == 3'd4);

  AST_CSR_WR_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && op_kind == 3'd6 |-> illegal); // R1

  AST_CSR_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && op_kind == 3'd6 |=> $stable(lp_start) && $stable(lp_end)); // R1

  AST_MISALIGN_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && reg_form && op_rdata[1:0] != 2'b00 |-> illegal); // R4

  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && reg_form && op_rdata[1:0] != 2'b00 |=> $stable(lp_start) && $stable(lp_end)); // R4

  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    branch_back |-> branch_target[1:0] == 2'b00); // R3

  AST_INNER_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !dec_valid && lp_count[CW-1:0] != '0 && fetch_pc == lp_end[AW-1:0]
    |=> lp_count[CW-1:0] == $past(lp_count[CW-1:0]) - CW'(1)); // R7

  AST_INNER_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !dec_valid && lp_count[CW-1:0] != '0 && fetch_pc == lp_end[AW-1:0]
    |=> $stable(lp_count[N_LOOPS*CW-1:CW])); // R9

  AST_INNER_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && lp_count[CW-1:0] > CW'(1) && fetch_pc == lp_end[AW-1:0]
    |-> branch_back && branch_target == lp_start[AW-1:0]); // R7

  for (genvar g = 0; g < N_LOOPS; g++) begin : g_al
    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      lp_start[g*AW +: 2] == 2'b00); // R3
    AST_END_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      lp_end[g*AW +: 2] == 2'b00); // R4
  end

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.N_LOOPS(N_LOOPS), .AW(AW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dec_valid     (dec_valid),
  .op_kind       (op_kind),
  .op_rdata      (op_rdata),
  .fetch_valid   (fetch_valid),
  .fetch_pc      (fetch_pc),
  .lp_start      (lp_start),
  .lp_end        (lp_end),
  .lp_count      (lp_count),
  .illegal       (illegal),
  .branch_back   (branch_back),
  .branch_target (branch_target)
);

// File: tb/hwloop_ctrl_test.sv
`timescale 1ns/1ps
module hwloop_ctrl_test;
  localparam int N = 2, AW = 32, CW = 16, IW = 12, LW = 1;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          dec_valid = 1'b0, fetch_valid = 1'b0;
  logic [2:0]    op_kind = '0, dec_class = '0;
  logic [LW-1:0] op_loop = '0;
  logic [IW-1:0] op_imm = '0;
  logic [AW-1:0] op_rdata = '0, dec_pc = '0, fetch_pc = '0;
  logic [N*AW-1:0] lp_start, lp_end;
  logic [N*CW-1:0] lp_count;
  logic          illegal, branch_back;
  logic [AW-1:0] branch_target;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hwloop_ctrl #(.N_LOOPS(N), .AW(AW), .CW(CW), .IMM_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .op_kind(op_kind),
    .op_loop(op_loop), .op_imm(op_imm), .op_rdata(op_rdata), .dec_pc(dec_pc),
    .dec_class(dec_class), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .lp_start(lp_start), .lp_end(lp_end), .lp_count(lp_count),
    .illegal(illegal), .branch_back(branch_back), .branch_target(branch_target)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    dec_valid = 0; op_kind = 0; dec_class = 0; fetch_valid = 0;
  endtask

  task automatic setup(input logic [2:0] k, input logic [LW-1:0] l,
                       input logic [IW-1:0] imm, input logic [AW-1:0] rd,
                       input logic [AW-1:0] pc);
    dec_valid = 1; op_kind = k; op_loop = l; op_imm = imm; op_rdata = rd;
    dec_pc = pc; dec_class = 0;
    tick(); idle();
  endtask

  function automatic logic [AW-1:0] st(input int i); return lp_start[i*AW +: AW]; endfunction
  function automatic logic [AW-1:0] en(input int i); return lp_end[i*AW +: AW]; endfunction
  function automatic logic [CW-1:0] ct(input int i); return lp_count[i*CW +: CW]; endfunction

  // {pc[31:0], class[2:0], kind[2:0], rdata[31:0], expected illegal}
  localparam logic [70:0] VEC [15] = '{
    {32'h110, 3'd1, 3'd0, 32'h0,   1'b1},  // R5 jump inside
    {32'h110, 3'd2, 3'd0, 32'h0,   1'b1},  // R5 branch
    {32'h110, 3'd3, 3'd0, 32'h0,   1'b1},  // R5 mret
    {32'h110, 3'd4, 3'd0, 32'h0,   1'b1},  // R5 dret
    {32'h110, 3'd5, 3'd0, 32'h0,   1'b1},  // R5 wfi
    {32'h110, 3'd6, 3'd0, 32'h0,   1'b1},  // R5 ecall
    {32'h150, 3'd7, 3'd0, 32'h0,   1'b1},  // R5 fence, outer body only
    {32'h110, 3'd0, 3'd0, 32'h0,   1'b0},  // R5 other class
    {32'h300, 3'd1, 3'd0, 32'h0,   1'b0},  // R5 outside
    {32'h080, 3'd2, 3'd0, 32'h0,   1'b1},  // R6 first address inclusive
    {32'h200, 3'd7, 3'd0, 32'h0,   1'b1},  // R6 last address inclusive
    {32'h07C, 3'd1, 3'd0, 32'h0,   1'b0},  // R6 below
    {32'h204, 3'd1, 3'd0, 32'h0,   1'b0},  // R6 above
    {32'h300, 3'd0, 3'd6, 32'h104, 1'b1},  // R1 CSR write
    {32'h300, 3'd0, 3'd3, 32'h102, 1'b1}   // R4 misaligned start
  };

  initial begin
    #4000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R11 count0 reset", ct(0), 0);
    check("R11 count1 reset", ct(1), 0);
    check("R11 start reset", lp_start, 0);
    check("R11 no branch", branch_back, 0);
    rst_n = 1;
    tick();

    setup(3'd3, 0, 0, 32'h100, 0);
    setup(3'd4, 0, 0, 32'h120, 0);
    setup(3'd5, 0, 0, 32'd3, 0);
    check("R2 start0", st(0), 32'h100);
    check("R2 end0", en(0), 32'h120);
    check("R10 count0", ct(0), 3);
    setup(3'd1, 1, 12'h010, 0, 32'h40);     // 0x40 + 0x40
    setup(3'd2, 1, 12'h040, 0, 32'h100);    // 0x100 + 0x100
    setup(3'd5, 1, 0, 32'd2, 0);
    check("R3 start1 imm", st(1), 32'h80);
    check("R3 end1 imm", en(1), 32'h200);

    foreach (VEC[i]) begin
      dec_valid = 1; op_loop = 0; op_imm = 0;
      dec_pc = VEC[i][70:39]; dec_class = VEC[i][38:36];
      op_kind = VEC[i][35:33]; op_rdata = VEC[i][32:1];
      #1;
      check($sformatf("R5/R6/R1/R4 vec%0d illegal (R11 comb)", i), illegal, VEC[i][0]);
      tick(); idle();
    end
    check("R1 R4 start0 unchanged", st(0), 32'h100);
    check("R1 end0 unchanged", en(0), 32'h120);

    dec_valid = 1; op_kind = 3'd4; op_loop = 1; op_rdata = 32'h201; dec_pc = 0;
    #1 check("R4 misaligned end illegal", illegal, 1);
    tick(); idle();
    check("R4 end1 unchanged", en(1), 32'h200);

    // negative immediate: 0x400 - 16
    setup(3'd1, 1, 12'hFFC, 0, 32'h400);
    check("R3 negative imm", st(1), 32'h3F0);
    setup(3'd3, 1, 0, 32'h80, 0);

    // illegal setup inside a body writes nothing
    dec_valid = 1; op_kind = 3'd5; op_loop = 0; op_rdata = 7; dec_pc = 32'h110; dec_class = 1;
    tick(); idle();
    check("R12 illegal setup no write", ct(0), 3);

    fetch_valid = 1; fetch_pc = 32'h120; #1;
    check("R7 branch_back", branch_back, 1);
    check("R7 target", branch_target, 32'h100);
    tick();
    check("R7 count 3->2", ct(0), 2);
    tick();
    check("R7 count 2->1", ct(0), 1);
    check("R8 no branch at 1", branch_back, 0);
    tick();
    check("R8 count 1->0", ct(0), 0);
    check("R10 no branch at 0", branch_back, 0);
    tick();
    check("R10 stays 0", ct(0), 0);
    idle();

    setup(3'd4, 0, 0, 32'h200, 0);
    setup(3'd5, 0, 0, 32'd2, 0);
    fetch_valid = 1; fetch_pc = 32'h200; #1;
    check("R9 branch_back", branch_back, 1);
    check("R9 inner target", branch_target, 32'h100);
    tick(); idle();
    check("R9 inner decremented", ct(0), 1);
    check("R9 outer untouched", ct(1), 2);

    fetch_valid = 1; fetch_pc = 32'h200;
    dec_valid = 1; op_kind = 3'd5; op_loop = 0; op_rdata = 5; dec_class = 0;
    tick(); idle();
    check("R12 write beats decrement", ct(0), 5);

    setup(3'd5, 0, 0, 0, 0);
    setup(3'd5, 1, 0, 0, 0);
    fetch_valid = 1; fetch_pc = 32'h200;
    dec_valid = 1; op_kind = 0; dec_pc = 32'h150; dec_class = 1; #1;
    check("R10 zero count no branch", branch_back, 0);
    check("R6 inactive loop legal", illegal, 0);
    tick(); idle();

    setup(3'd5, 1, 0, 9, 0);
    rst_n = 0; tick(); rst_n = 1;
    check("R11 reset clears count", ct(1), 0);
    check("R11 reset clears end", lp_end, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule